// File: doc/BRIEF.md
# Debug Profiling Counter Unit

This block gives debug software a small set of performance counters that it reads and presets over a simple 32-bit word-addressed register bus. A 32-bit cycle counter runs while its enable bit is set. Five 8-bit event counters accumulate core events: extra instruction cycles, exception overhead cycles, sleep cycles, load/store extra cycles and zero-cycle (folded) instructions. A read-only capability word reports which features are built in and how many comparators exist. A read-only register holds the most recent program-counter sample from the core.

The unit comes out of reset locked. Software must write an unlock key to a write-only lock register before any other register write takes effect. Reads work at all times. The cycle-counter enable bit can only change while the core's global trace enable is high. Event inputs are driven by the core, one cycle per event or per sleeping cycle.

Top module: `dpc_top`

## Requirements
- R1: After reset the unit is locked, the cycle-counter enable is 0 and all counters and the program-counter sample read 0.
- R2: The capability word at word index 0 reads the NUM_COMP parameter in bits 31:28. It reads 1 in bit 27 (no trace packets) and 1 in bit 26 (no external match), and 0 in bit 25 (cycle counter present) and bit 24 (profiling counters present). Bit 0 is the cycle-counter enable and bits 23:1 read 0.
- R3: While locked, writes to word indices 0 to 7 have no effect and reads return current values. Writing 0xC5ACCE55 to index 8 unlocks the unit, and any other value written there locks it. Index 9 reads bit 0 = 1 (lock present) and bit 1 = locked. Index 8 reads 0.
- R4: A write to the enable bit (index 0, bit 0) takes effect only while trace_en is high. Otherwise it is ignored.
- R5: The cycle counter (index 1) adds 1 on every clock while enabled, wraps modulo 2^32, and can be preset by a write.
- R6: The event counters sit at index 2 (extra cycles), 3 (exception), 4 (sleep), 5 (load/store) and 6 (fold). Each is 8 bits wide, adds 1 for each cycle its input is high, wraps from 255 to 0, and keeps only bits 7:0 of a write.
- R7: The extra-cycle counter does not advance in a cycle where the load/store event is also high.
- R8: A write to a counter in the same cycle as its increment loads the written value, and the increment is lost.
- R9: The sleep counter advances once per cycle while the sleep level is high. The fold counter advances once per fold strobe.
- R10: Index 7 captures core_pc on each cycle core_pc_vld is high, holds its value otherwise, and ignores bus writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trace_en | input | 1 | Global trace enable; gates changes to the cycle-counter enable |
| ev_cpi | input | 1 | Extra instruction cycle / fetch stall strobe |
| ev_exc | input | 1 | Exception overhead cycle strobe |
| ev_sleep | input | 1 | Processor sleeping level |
| ev_lsu | input | 1 | Load/store extra cycle strobe |
| ev_fold | input | 1 | Folded instruction strobe |
| core_pc | input | 32 | Program counter value from the core |
| core_pc_vld | input | 1 | core_pc is valid this cycle |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
Two functions can land in the same clock edge. One is a software write to a counter in the same cycle as that counter's event strobe. The other is the extra-cycle and load/store strobes firing together. The bench provokes the first by driving a fold-counter write together with ev_fold. It expects the written value, with no +1 added. It provokes the second by raising ev_cpi and ev_lsu together for several cycles. It expects only the load/store count to move.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;
    localparam int NUM_EV = 5;

    localparam logic [ADDR_W-1:0] REG_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] REG_CYC  = 4'd1;
    localparam logic [ADDR_W-1:0] REG_EV0  = 4'd2;
    localparam logic [ADDR_W-1:0] REG_CPI  = 4'd2;
    localparam logic [ADDR_W-1:0] REG_LSU  = 4'd5;
    localparam logic [ADDR_W-1:0] REG_FOLD = 4'd6;
    localparam logic [ADDR_W-1:0] REG_PC   = 4'd7;
    localparam logic [ADDR_W-1:0] REG_LAR  = 4'd8;
    localparam logic [ADDR_W-1:0] REG_LSR  = 4'd9;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'hC5AC_CE55;
endpackage

// File: rtl/dpc_ev_counter.sv
module dpc_ev_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc) cnt_d = cnt_q + 1'b1;
        if (ld)  cnt_d = ld_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/dpc_lock.sv
module dpc_lock
    import dpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [DATA_W-1:0] key_val,
    output logic              locked
);
    logic locked_d, locked_q;

    always_comb begin
        locked_d = locked_q;
        if (key_wr) locked_d = (key_val != UNLOCK_KEY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) locked_q <= 1'b1;
        else        locked_q <= locked_d;
    end

    assign locked = locked_q;
endmodule

// File: rtl/dpc_top.sv
module dpc_top
    import dpc_pkg::*;
#(
    parameter int NUM_COMP = 4,
    parameter int EV_W     = 8,
    parameter int CYC_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trace_en,
    input  logic              ev_cpi,
    input  logic              ev_exc,
    input  logic              ev_sleep,
    input  logic              ev_lsu,
    input  logic              ev_fold,
    input  logic [31:0]       core_pc,
    input  logic              core_pc_vld,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [3:0] NCOMP_F = 4'(NUM_COMP);
    localparam logic [3:0] ABSENT_F = 4'b1100;

    typedef struct packed {
        logic             cyc_en;
        logic [CYC_W-1:0] cyc;
        logic [31:0]      pc;
    } state_t;

    state_t st_d, st_q;
    logic   locked;
    logic   wr_ok;
    logic   key_wr;
    logic [NUM_EV-1:0] ev_vec;
    logic [EV_W-1:0]   ev_cnt [NUM_EV];

    assign wr_ok  = bus_sel && bus_wr && !locked;
    assign key_wr = bus_sel && bus_wr && (bus_addr == REG_LAR);
    assign ev_vec = {ev_fold, ev_lsu, ev_sleep, ev_exc, ev_cpi && !ev_lsu};

    dpc_lock u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (key_wr),
        .key_val (bus_wdata),
        .locked  (locked)
    );

    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        dpc_ev_counter #(.W(EV_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (ev_vec[i]),
            .ld     (wr_ok && (bus_addr == REG_EV0 + ADDR_W'(i))),
            .ld_val (bus_wdata[EV_W-1:0]),
            .cnt    (ev_cnt[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (st_q.cyc_en) st_d.cyc = st_q.cyc + 1'b1;
        if (wr_ok && bus_addr == REG_CYC) st_d.cyc = bus_wdata[CYC_W-1:0];
        if (wr_ok && bus_addr == REG_CTRL && trace_en) st_d.cyc_en = bus_wdata[0];
        if (core_pc_vld) st_d.pc = core_pc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL: bus_rdata = {NCOMP_F, ABSENT_F, 23'd0, st_q.cyc_en};
            REG_CYC:  bus_rdata = DATA_W'(st_q.cyc);
            REG_PC:   bus_rdata = st_q.pc;
            REG_LSR:  bus_rdata = {30'd0, locked, 1'b1};
            default: begin
                for (int i = 0; i < NUM_EV; i++) begin
                    if (bus_addr == REG_EV0 + ADDR_W'(i)) bus_rdata = DATA_W'(ev_cnt[i]);
                end
            end
        endcase
    end
endmodule

// File: rtl/dpc_sva.sv
module dpc_sva
    import dpc_pkg::*;
#(
    parameter int EV_W  = 8,
    parameter int CYC_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trace_en,
    input logic              ev_cpi,
    input logic              ev_lsu,
    input logic              ev_fold,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              locked,
    input logic              cyc_en,
    input logic [CYC_W-1:0]  cyc,
    input logic [EV_W-1:0]   cpi_cnt,
    input logic [EV_W-1:0]   fold_cnt
);
    logic any_wr;
    assign any_wr = bus_sel && bus_wr;

    a_r3_locked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (any_wr && bus_addr == REG_FOLD && locked && !ev_fold) |=> $stable(fold_cnt));

    a_r3_bad_key_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (any_wr && bus_addr == REG_LAR && bus_wdata != UNLOCK_KEY) |=> locked);

    a_r4_enable_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !trace_en |=> $stable(cyc_en));

    a_r5_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && !(any_wr && !locked && bus_addr == REG_CYC))
        |=> cyc == CYC_W'($past(cyc) + 1'b1));

    a_r7_cpi_excluded: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_cpi && ev_lsu && !(any_wr && !locked && bus_addr == REG_CPI)) |=> $stable(cpi_cnt));

    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (any_wr && !locked && bus_addr == REG_FOLD) |=> fold_cnt == $past(bus_wdata[EV_W-1:0]));
endmodule

bind dpc_top dpc_sva #(.EV_W(EV_W), .CYC_W(CYC_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .trace_en  (trace_en),
    .ev_cpi    (ev_cpi),
    .ev_lsu    (ev_lsu),
    .ev_fold   (ev_fold),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .locked    (locked),
    .cyc_en    (st_q.cyc_en),
    .cyc       (st_q.cyc),
    .cpi_cnt   (ev_cnt[0]),
    .fold_cnt  (ev_cnt[4])
);

// File: tb/dpc_top_tb.sv
module dpc_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trace_en = 1'b0;
    logic        ev_cpi = 1'b0, ev_exc = 1'b0, ev_sleep = 1'b0, ev_lsu = 1'b0, ev_fold = 1'b0;
    logic [31:0] core_pc = '0;
    logic        core_pc_vld = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit rd_fire = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    dpc_top u_dut (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en),
        .ev_cpi(ev_cpi), .ev_exc(ev_exc), .ev_sleep(ev_sleep), .ev_lsu(ev_lsu), .ev_fold(ev_fold),
        .core_pc(core_pc), .core_pc_vld(core_pc_vld),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // monitor: compares read data against the queued expectation
    always @(negedge clk) begin
        if (rd_fire && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                failures++;
                $display("FAIL %s: got 0x%08h expected 0x%08h", t, bus_rdata, e);
            end
        end
    end

    task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #2;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        rd_fire = 1'b1;
        @(negedge clk); #1;
        rd_fire = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // mask bits: 0 cpi, 1 exc, 2 sleep, 3 lsu, 4 fold
    task automatic ev(input logic [4:0] m, input int n);
        @(posedge clk); #2;
        {ev_fold, ev_lsu, ev_sleep, ev_exc, ev_cpi} = m;
        repeat (n) @(posedge clk);
        #2;
        {ev_fold, ev_lsu, ev_sleep, ev_exc, ev_cpi} = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 / R2 reset state and capability word
        rd(4'd0, 32'h4C00_0000, "R1 R2 ctrl after reset");
        rd(4'd1, 32'h0, "R1 cycle count after reset");
        rd(4'd6, 32'h0, "R1 fold after reset");
        rd(4'd7, 32'h0, "R1 pc sample after reset");
        rd(4'd9, 32'h3, "R1 R3 lock status after reset");
        // R3 locked writes ignored
        wr(4'd1, 32'h0000_1234);
        rd(4'd1, 32'h0, "R3 cycle write while locked");
        wr(4'd6, 32'h55);
        rd(4'd6, 32'h0, "R3 fold write while locked");
        trace_en = 1'b1;
        wr(4'd0, 32'h1);
        rd(4'd0, 32'h4C00_0000, "R3 ctrl write while locked");
        wr(4'd8, 32'h1234_5678);
        rd(4'd9, 32'h3, "R3 wrong key keeps lock");
        wr(4'd8, 32'hC5AC_CE55);
        rd(4'd9, 32'h1, "R3 key unlocks");
        rd(4'd8, 32'h0, "R3 lock access reads zero");
        // R4 enable gated by trace_en
        trace_en = 1'b0;
        wr(4'd0, 32'h1);
        rd(4'd0, 32'h4C00_0000, "R4 enable ignored without trace_en");
        // R5 preset, count, wrap
        wr(4'd1, 32'd100);
        rd(4'd1, 32'd100, "R5 preset");
        trace_en = 1'b1;
        wr(4'd0, 32'h1);
        idle(5);
        wr(4'd0, 32'h0);
        rd(4'd1, 32'd107, "R5 counting span");
        rd(4'd0, 32'h4C00_0000, "R4 enable cleared");
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd0, 32'h1);
        wr(4'd0, 32'h0);
        rd(4'd1, 32'h1, "R5 wrap");
        // R6 width and wrap
        wr(4'd3, 32'h0000_01AB);
        rd(4'd3, 32'hAB, "R6 write keeps low byte");
        ev(5'b00010, 3);
        rd(4'd3, 32'hAE, "R6 exception counting");
        wr(4'd6, 32'hFE);
        ev(5'b10000, 3);
        rd(4'd6, 32'h01, "R6 R9 fold wrap");
        // R7 extra-cycle exclusion
        ev(5'b00001, 2);
        rd(4'd2, 32'd2, "R7 extra cycles alone");
        ev(5'b01001, 3);
        rd(4'd2, 32'd2, "R7 extra cycles with load/store");
        rd(4'd5, 32'd3, "R7 load/store counted");
        // R8 write over increment
        @(posedge clk); #2;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd6; bus_wdata = 32'h40; ev_fold = 1'b1;
        @(posedge clk); #2;
        bus_sel = 1'b0; bus_wr = 1'b0; ev_fold = 1'b0;
        rd(4'd6, 32'h40, "R8 write beats increment");
        // R9 sleep level
        ev(5'b00100, 7);
        rd(4'd4, 32'd7, "R9 sleep cycles");
        // R10 pc sample
        @(posedge clk); #2;
        core_pc = 32'hDEAD_BEE0; core_pc_vld = 1'b1;
        @(posedge clk); #2;
        core_pc = 32'h1111_2222; core_pc_vld = 1'b0;
        idle(2);
        rd(4'd7, 32'hDEAD_BEE0, "R10 pc captured and held");
        wr(4'd7, 32'h0);
        rd(4'd7, 32'hDEAD_BEE0, "R10 pc write ignored");
        // R3 relock
        wr(4'd8, 32'h0);
        rd(4'd9, 32'h3, "R3 relock");
        wr(4'd3, 32'h0);
        rd(4'd3, 32'hAE, "R3 write after relock ignored");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule